// File: doc/BRIEF.md
# Serial host request handshake controller

This block owns the request/flow-control pin of a serial host port that can run as SPI or I2C, as master or as slave. It holds the two-bit request-enable field and the master select. From these and the protocol select it decides whether the pin is an input, an output or undriven.

In master mode with requests enabled, the pin is an active-low input. It is passed through a synchronizer, and its deasserted level holds the serial clock in a suspended state. The run/suspend output changes only while the serial clock is idle, so a clock pulse is never cut short.

In slave mode the pin is an active-low output that reports readiness of the shift register for transmit, receive or both. The "both" encoding means OR under I2C and AND under SPI. A sticky bus-error flag catches an active slave-select while the port is an SPI master.

Top module: `host_req_ctrl`

## Requirements
- R1: With request-enable field 00, `req_oe_o` is 0 and `req_n_o` is 1 in every mode.
- R2: In master mode (`cfg_master_o`=1) with a nonzero request-enable field, `req_oe_o` is 0 and `req_n_o` is 1; the pin is an input.
- R3: In master mode with a nonzero field, `sck_run_o` is 1 when `req_n_i` is low and 0 when it is high. The input passes `SYNC_STAGES` (default 2) flops before one output register, so with `sck_idle_i`=1 a change on `req_n_i` shows on `sck_run_o` three clock edges later. In slave mode, or with field 00, the target is run (1).
- R4: In slave mode with field 01, `req_oe_o`=1 and `req_n_o` = NOT `rx_ready_i`.
- R5: In slave mode with field 10, `req_oe_o`=1 and `req_n_o` = NOT `tx_ready_i`.
- R6: In slave mode with field 11 and `proto_i2c_i`=1, `req_n_o` = NOT (`tx_ready_i` OR `rx_ready_i`).
- R7: In slave mode with field 11 and `proto_i2c_i`=0 (SPI), `req_n_o` = NOT (`tx_ready_i` AND `rx_ready_i`).
- R8: In SPI master mode, `ss_n_i`=0 sets `bus_err_o` on the next edge. In I2C mode or slave mode, slave-select has no effect on the flag.
- R9: `bus_err_o` stays set until a cycle with `berr_clr_i`=1 and no new error, or until a reset.
- R10: A write with `cfg_we_i`=1 while `busy_i`=1 leaves the request-enable field unchanged. The master bit is written regardless of `busy_i`. Written values show on `cfg_req_en_o`/`cfg_master_o` after the edge.
- R11: Both `rst_ni`=0 and a cycle with `soft_rst_i`=1 clear the request-enable field, the master bit and `bus_err_o`, and set `sck_run_o` to 1.
- R12: While `sck_idle_i`=0, `sck_run_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| soft_rst_i | input | 1 | Synchronous software reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_req_en_i | input | 2 | Request-enable field write data |
| cfg_master_i | input | 1 | Master select write data |
| proto_i2c_i | input | 1 | 1 = I2C, 0 = SPI |
| busy_i | input | 1 | Interface busy |
| tx_ready_i | input | 1 | Shift register ready to supply a transmit word |
| rx_ready_i | input | 1 | Shift register ready to accept a received word |
| sck_idle_i | input | 1 | Serial clock at a bit boundary |
| req_n_i | input | 1 | Request pin input, active low |
| ss_n_i | input | 1 | SPI slave-select, active low |
| berr_clr_i | input | 1 | Clear bus-error flag |
| req_n_o | output | 1 | Request pin output value, active low |
| req_oe_o | output | 1 | Request pin output enable |
| sck_run_o | output | 1 | 1 = serial clock may run, 0 = suspended |
| bus_err_o | output | 1 | Sticky bus-error flag |
| cfg_req_en_o | output | 2 | Current request-enable field |
| cfg_master_o | output | 1 | Current master select |

## Verification
The checker takes `ss_n_i`, `proto_i2c_i` and the readiness flags as already synchronous to `clk_i`. It also takes `sck_idle_i` to be a true bit-boundary indication, so holding `sck_run_o` while it is low is legal. Only `req_n_i` is treated as asynchronous.

The bench changes inputs on the falling edge only. Random configurations are written with `busy_i` low so that they take effect. The busy case, the clock-suspend timing and the slave-select error are driven as directed sequences.

// File: rtl/host_req_pkg.sv
`timescale 1ns/1ps
package host_req_pkg;
  typedef enum logic [1:0] {
    REQ_OFF  = 2'b00,
    REQ_RX   = 2'b01,
    REQ_TX   = 2'b10,
    REQ_BOTH = 2'b11
  } req_mode_e;
endpackage

// File: rtl/host_req_cfg.sv
`timescale 1ns/1ps
module host_req_cfg
  import host_req_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      soft_rst_i,
  input  logic      we_i,
  input  logic      busy_i,
  input  logic [1:0] req_en_i,
  input  logic      master_i,
  output req_mode_e mode_o,
  output logic      master_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o   <= REQ_OFF;
      master_o <= 1'b0;
    end else if (soft_rst_i) begin
      mode_o   <= REQ_OFF;
      master_o <= 1'b0;
    end else if (we_i) begin
      master_o <= master_i;
      // field change only legal while idle
      if (!busy_i) mode_o <= req_mode_e'(req_en_i);
    end
  end
endmodule

// File: rtl/host_req_sync.sv
`timescale 1ns/1ps
module host_req_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        INIT   = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic soft_rst_i,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned LAST = STAGES - 1;
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic nxt;
    if (g == 0) begin : g_first
      assign nxt = d_i;
    end else begin : g_rest
      assign nxt = chain_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         chain_q[g] <= INIT;
      else if (soft_rst_i) chain_q[g] <= INIT;
      else                 chain_q[g] <= nxt;
    end
  end

  assign q_o = chain_q[LAST];
endmodule

// File: rtl/host_req_decode.sv
`timescale 1ns/1ps
module host_req_decode
  import host_req_pkg::*;
(
  input  req_mode_e mode_i,
  input  logic      master_i,
  input  logic      i2c_i,
  input  logic      tx_ready_i,
  input  logic      rx_ready_i,
  output logic      req_n_o,
  output logic      req_oe_o
);
  logic active;

  always_comb begin
    unique case (mode_i)
      REQ_RX:   active = rx_ready_i;
      REQ_TX:   active = tx_ready_i;
      REQ_BOTH: active = i2c_i ? (tx_ready_i | rx_ready_i)
                               : (tx_ready_i & rx_ready_i);
      default:  active = 1'b0;
    endcase
  end

  assign req_oe_o = (mode_i != REQ_OFF) && !master_i;
  assign req_n_o  = req_oe_o ? !active : 1'b1;
endmodule

// File: rtl/host_req_master.sv
`timescale 1ns/1ps
module host_req_master
  import host_req_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      soft_rst_i,
  input  req_mode_e mode_i,
  input  logic      master_i,
  input  logic      i2c_i,
  input  logic      req_sync_n_i,
  input  logic      sck_idle_i,
  input  logic      ss_n_i,
  input  logic      berr_clr_i,
  output logic      sck_run_o,
  output logic      bus_err_o
);
  logic run_target;
  logic err_hit;

  assign run_target = (master_i && mode_i != REQ_OFF) ? !req_sync_n_i : 1'b1;
  assign err_hit    = master_i && !i2c_i && !ss_n_i;

  // suspend/resume only at a bit boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sck_run_o <= 1'b1;
    else if (soft_rst_i) sck_run_o <= 1'b1;
    else if (sck_idle_i) sck_run_o <= run_target;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         bus_err_o <= 1'b0;
    else if (soft_rst_i) bus_err_o <= 1'b0;
    else if (err_hit)    bus_err_o <= 1'b1;
    else if (berr_clr_i) bus_err_o <= 1'b0;
  end
endmodule

// File: rtl/host_req_ctrl.sv
`timescale 1ns/1ps
module host_req_ctrl
  import host_req_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       soft_rst_i,
  input  logic       cfg_we_i,
  input  logic [1:0] cfg_req_en_i,
  input  logic       cfg_master_i,
  input  logic       proto_i2c_i,
  input  logic       busy_i,
  input  logic       tx_ready_i,
  input  logic       rx_ready_i,
  input  logic       sck_idle_i,
  input  logic       req_n_i,
  input  logic       ss_n_i,
  input  logic       berr_clr_i,
  output logic       req_n_o,
  output logic       req_oe_o,
  output logic       sck_run_o,
  output logic       bus_err_o,
  output logic [1:0] cfg_req_en_o,
  output logic       cfg_master_o
);
  req_mode_e mode;
  logic      master;
  logic      req_sync_n;

  host_req_cfg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .we_i       (cfg_we_i),
    .busy_i     (busy_i),
    .req_en_i   (cfg_req_en_i),
    .master_i   (cfg_master_i),
    .mode_o     (mode),
    .master_o   (master)
  );

  host_req_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .soft_rst_i (soft_rst_i),
    .d_i        (req_n_i),
    .q_o        (req_sync_n)
  );

  host_req_decode u_dec (
    .mode_i     (mode),
    .master_i   (master),
    .i2c_i      (proto_i2c_i),
    .tx_ready_i (tx_ready_i),
    .rx_ready_i (rx_ready_i),
    .req_n_o    (req_n_o),
    .req_oe_o   (req_oe_o)
  );

  host_req_master u_mst (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .soft_rst_i   (soft_rst_i),
    .mode_i       (mode),
    .master_i     (master),
    .i2c_i        (proto_i2c_i),
    .req_sync_n_i (req_sync_n),
    .sck_idle_i   (sck_idle_i),
    .ss_n_i       (ss_n_i),
    .berr_clr_i   (berr_clr_i),
    .sck_run_o    (sck_run_o),
    .bus_err_o    (bus_err_o)
  );

  assign cfg_req_en_o = mode;
  assign cfg_master_o = master;
endmodule

// File: rtl/host_req_ctrl_chk.sv
`timescale 1ns/1ps
module host_req_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       soft_rst_i,
  input logic       cfg_we_i,
  input logic       proto_i2c_i,
  input logic       busy_i,
  input logic       tx_ready_i,
  input logic       rx_ready_i,
  input logic       sck_idle_i,
  input logic       ss_n_i,
  input logic       berr_clr_i,
  input logic       req_n_o,
  input logic       req_oe_o,
  input logic       sck_run_o,
  input logic       bus_err_o,
  input logic [1:0] cfg_req_en_o,
  input logic       cfg_master_o
);
  p_hiz_when_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_req_en_o == 2'b00) |-> (!req_oe_o && req_n_o));

  p_master_input_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_master_o |-> !req_oe_o);

  p_rx_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_master_o && cfg_req_en_o == 2'b01) |-> (req_oe_o && req_n_o == !rx_ready_i));

  p_tx_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_master_o && cfg_req_en_o == 2'b10) |-> (req_oe_o && req_n_o == !tx_ready_i));

  p_i2c_either_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_master_o && cfg_req_en_o == 2'b11 && proto_i2c_i && (tx_ready_i || rx_ready_i))
      |-> !req_n_o);

  p_spi_both_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_master_o && cfg_req_en_o == 2'b11 && !proto_i2c_i && !(tx_ready_i && rx_ready_i))
      |-> req_n_o);

  p_berr_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_master_o && !proto_i2c_i && !ss_n_i && !soft_rst_i) |=> bus_err_o);

  p_berr_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_err_o && !berr_clr_i && !soft_rst_i) |=> bus_err_o);

  p_busy_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && busy_i && !soft_rst_i) |=> $stable(cfg_req_en_o));

  p_soft_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (cfg_req_en_o == 2'b00 && !cfg_master_o && !bus_err_o && sck_run_o));

  p_run_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sck_idle_i && !soft_rst_i) |=> $stable(sck_run_o));
endmodule

bind host_req_ctrl host_req_ctrl_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .soft_rst_i   (soft_rst_i),
  .cfg_we_i     (cfg_we_i),
  .proto_i2c_i  (proto_i2c_i),
  .busy_i       (busy_i),
  .tx_ready_i   (tx_ready_i),
  .rx_ready_i   (rx_ready_i),
  .sck_idle_i   (sck_idle_i),
  .ss_n_i       (ss_n_i),
  .berr_clr_i   (berr_clr_i),
  .req_n_o      (req_n_o),
  .req_oe_o     (req_oe_o),
  .sck_run_o    (sck_run_o),
  .bus_err_o    (bus_err_o),
  .cfg_req_en_o (cfg_req_en_o),
  .cfg_master_o (cfg_master_o)
);

// File: tb/host_req_ctrl_tb_top.sv
`timescale 1ns/1ps
module host_req_ctrl_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       soft_rst_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [1:0] cfg_req_en_i = 2'b00;
  logic       cfg_master_i = 1'b0;
  logic       proto_i2c_i = 1'b0;
  logic       busy_i = 1'b0;
  logic       tx_ready_i = 1'b0;
  logic       rx_ready_i = 1'b0;
  logic       sck_idle_i = 1'b1;
  logic       req_n_i = 1'b1;
  logic       ss_n_i = 1'b1;
  logic       berr_clr_i = 1'b0;
  logic       req_n_o, req_oe_o, sck_run_o, bus_err_o, cfg_master_o;
  logic [1:0] cfg_req_en_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          done = 1'b0;

  always #2 clk_i = ~clk_i;

  host_req_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
    .cfg_we_i(cfg_we_i), .cfg_req_en_i(cfg_req_en_i), .cfg_master_i(cfg_master_i),
    .proto_i2c_i(proto_i2c_i), .busy_i(busy_i), .tx_ready_i(tx_ready_i),
    .rx_ready_i(rx_ready_i), .sck_idle_i(sck_idle_i), .req_n_i(req_n_i),
    .ss_n_i(ss_n_i), .berr_clr_i(berr_clr_i), .req_n_o(req_n_o),
    .req_oe_o(req_oe_o), .sck_run_o(sck_run_o), .bus_err_o(bus_err_o),
    .cfg_req_en_o(cfg_req_en_o), .cfg_master_o(cfg_master_o)
  );

  function automatic logic exp_oe(logic m, logic [1:0] en);
    return (en != 2'b00) && !m;
  endfunction

  function automatic logic exp_req_n(logic m, logic [1:0] en, logic i2c, logic tx, logic rx);
    if (m || en == 2'b00) return 1'b1;
    case (en)
      2'b01:   return !rx;
      2'b10:   return !tx;
      default: return i2c ? !(tx | rx) : !(tx & rx);
    endcase
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_cfg(logic m, logic [1:0] en);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_master_i = m; cfg_req_en_i = en;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  function automatic string req_tag(logic [1:0] en, logic i2c);
    case (en)
      2'b00:   return "R1";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return i2c ? "R6" : "R7";
    endcase
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    cycles(3);
    // R11 hardware reset state
    check("R11 reset oe", req_oe_o, 0);
    check("R11 reset req_n", req_n_o, 1);
    check("R11 reset run", sck_run_o, 1);
    check("R11 reset err", bus_err_o, 0);
    check("R11 reset en", cfg_req_en_o, 0);
    rst_ni = 1'b1;
    cycles(2);

    // R1 field 00 in each mode
    for (int m = 0; m < 2; m++) begin
      wr_cfg(m[0], 2'b00);
      tx_ready_i = 1'b1; rx_ready_i = 1'b1;
      #1;
      check("R1 oe off", req_oe_o, 0);
      check("R1 req_n off", req_n_o, 1);
    end

    // random slave/master decode: R1 R2 R4 R5 R6 R7
    for (int k = 0; k < 60; k++) begin
      logic       m;
      logic [1:0] en;
      m  = ($urandom % 4) == 0;
      en = 2'($urandom);
      wr_cfg(m, en);
      for (int j = 0; j < 8; j++) begin
        @(negedge clk_i);
        tx_ready_i  = 1'($urandom);
        rx_ready_i  = 1'($urandom);
        proto_i2c_i = 1'($urandom);
        #1;
        check(m ? "R2" : req_tag(en, proto_i2c_i), req_oe_o, exp_oe(m, en));
        check(m ? "R2" : req_tag(en, proto_i2c_i), req_n_o,
              exp_req_n(m, en, proto_i2c_i, tx_ready_i, rx_ready_i));
      end
    end

    // directed R6/R7 on the mode-11 split
    wr_cfg(1'b0, 2'b11);
    @(negedge clk_i); tx_ready_i = 1; rx_ready_i = 0; proto_i2c_i = 1; #1;
    check("R6 i2c either", req_n_o, 0);
    @(negedge clk_i); proto_i2c_i = 0; #1;
    check("R7 spi both", req_n_o, 1);
    @(negedge clk_i); rx_ready_i = 1; #1;
    check("R7 spi both ready", req_n_o, 0);

    // R3 clock suspend via synchronized request input
    proto_i2c_i = 1'b1;
    req_n_i = 1'b1; sck_idle_i = 1'b1;
    wr_cfg(1'b1, 2'b01);
    cycles(1);
    check("R2 master oe", req_oe_o, 0);
    check("R3 suspended", sck_run_o, 0);
    req_n_i = 1'b0;
    cycles(2);
    check("R3 not yet", sck_run_o, 0);
    cycles(1);
    check("R3 resumed", sck_run_o, 1);
    // R12 hold while not idle
    sck_idle_i = 1'b0; req_n_i = 1'b1;
    cycles(6);
    check("R12 hold", sck_run_o, 1);
    sck_idle_i = 1'b1;
    cycles(1);
    check("R12 idle apply", sck_run_o, 0);
    req_n_i = 1'b0;
    cycles(3);
    check("R3 resume again", sck_run_o, 1);

    // R8 bus error: I2C master ignores ss
    ss_n_i = 1'b0;
    cycles(1);
    ss_n_i = 1'b1;
    check("R8 i2c no err", bus_err_o, 0);
    proto_i2c_i = 1'b0;
    wr_cfg(1'b0, 2'b01);
    ss_n_i = 1'b0;
    cycles(1);
    ss_n_i = 1'b1;
    check("R8 slave no err", bus_err_o, 0);
    wr_cfg(1'b1, 2'b00);
    ss_n_i = 1'b0;
    cycles(1);
    ss_n_i = 1'b1;
    check("R8 spi master err", bus_err_o, 1);
    cycles(4);
    check("R9 sticky", bus_err_o, 1);
    berr_clr_i = 1'b1;
    cycles(1);
    berr_clr_i = 1'b0;
    check("R9 cleared", bus_err_o, 0);

    // R10 busy write ignored for field, master still taken
    wr_cfg(1'b1, 2'b10);
    busy_i = 1'b1;
    wr_cfg(1'b0, 2'b11);
    busy_i = 1'b0;
    check("R10 field kept", cfg_req_en_o, 2'b10);
    check("R10 master taken", cfg_master_o, 0);
    #1;
    check("R10 pin tracks kept field", req_oe_o, 1);

    // R11 soft reset
    wr_cfg(1'b1, 2'b11);
    ss_n_i = 1'b0;
    req_n_i = 1'b1;
    cycles(4);
    ss_n_i = 1'b1;
    check("R11 pre err", bus_err_o, 1);
    soft_rst_i = 1'b1;
    cycles(1);
    soft_rst_i = 1'b0;
    check("R11 soft en", cfg_req_en_o, 0);
    check("R11 soft master", cfg_master_o, 0);
    check("R11 soft err", bus_err_o, 0);
    check("R11 soft run", sck_run_o, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule